// File: doc/BRIEF.md
# Soft-Start and Fault Hiccup Sequencer

This block decides when a peak-current-mode converter may switch, and how hard the control input is clamped while it does. It keeps a digital soft-start level that stands in for the voltage on a soft-start capacitor. The level rises and falls in whole steps. There are two step sizes: a fast step and a slow step. The level appears on `clamp`, and the PWM stage limits its control input to it. The output `run` gates the drivers. Every analog comparison reaches the block already resolved as a digital flag.

Start-up has two phases. The level first climbs quickly to the baseline where duty begins. It then climbs slowly to a resting plateau. While running, cycles that end in a light overcurrent push the level up, and clean cycles let it fall back to the plateau. If it climbs as far as the overload ceiling, the block performs a slow hiccup. A severe overcurrent or a supply overvoltage causes a fast hiccup. After a set number of fast hiccups in a row, the block locks off until reset. Over-temperature, and a power-good drop while soft stop is enabled, cause a soft stop: the drivers keep switching while the level falls. Undervoltage, and a power-good drop with soft stop disabled, stop the drivers at once.

Top module: `ss_hiccup_seq`

## Requirements
- R1: After reset `clamp` is 0, `run` is low and `latched` is low. A start begins only while `pgood` is high and both `uv_flag` and `ot_flag` are low.
- R2: A start raises `clamp` by FAST (5) per clock up to BASE (20) with `run` low. It then raises `clamp` by SLOW (1) per clock up to PLATEAU (60) with `run` high.
- R3: While running, each clock with `cyc_end` high and `oc1_evt` high raises `clamp` by SLOW. Each clock with `cyc_end` high and `oc1_evt` low lowers `clamp` by SLOW, but never below PLATEAU.
- R4: When `clamp` reaches OVLD (80), `run` goes low on that same clock edge. `clamp` then falls by SLOW per clock to 0, and a new start follows.
- R5: `oc2_flag` or `ov_flag` makes `run` low on the next clock. `clamp` then falls by FAST per clock to 0, and a start is retried.
- R6: After TRIES (4) such fast hiccups with no plateau reached in between, `latched` goes high, `run` stays low and `clamp` stays 0 until reset.
- R7: `ot_flag` starts a soft stop: `run` stays high while `clamp` falls by FAST per clock to 0. A restart waits until `ot_flag` is low.
- R8: `uv_flag` makes `run` low on the next clock and `clamp` falls by FAST per clock to 0. A restart waits until `uv_flag` is low.
- R9: `pgood` going low starts a soft stop (as in R7) when `softstop_en` is high. It stops the drivers at once (as in R8) when `softstop_en` is low.
- R10: The count of fast hiccups returns to zero each time a start reaches PLATEAU.
- R11: `clamp` never exceeds OVLD and changes by at most FAST between clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (models a full power cycle) |
| pgood | input | 1 | Power good; high permits operation |
| uv_flag | input | 1 | Supply undervoltage |
| ov_flag | input | 1 | Supply overvoltage |
| ot_flag | input | 1 | Over-temperature |
| oc2_flag | input | 1 | Severe (level-2) overcurrent |
| oc1_evt | input | 1 | The cycle ending now saw a level-1 overcurrent |
| cyc_end | input | 1 | PWM cycle boundary strobe |
| softstop_en | input | 1 | High enables soft stop on power-good loss |
| run | output | 1 | Driver enable to the PWM stage |
| clamp | output | W | Soft-start clamp level |
| latched | output | 1 | Locked off after repeated fast hiccups |

## Verification
The hardest case to reach is the lock-off and its counterpart, the clearing of the hiccup count. Four fast hiccups must happen in a row, and none of them may be interrupted by a start that reaches the plateau. The stimulus holds the overvoltage flag high while power good stays up. Each retry then fails during pre-charge, so the attempts follow one another every three clocks until the lock. A second directed case performs three hiccups, lets one start reach the plateau, and then performs three more. It checks that the block starts again rather than locking.

// File: rtl/ss_hiccup_seq.sv
module ss_hiccup_seq #(
  parameter int W       = 8,
  parameter int BASE    = 20,
  parameter int PLATEAU = 60,
  parameter int OVLD    = 80,
  parameter int FAST    = 5,
  parameter int SLOW    = 1,
  parameter int TRIES   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pgood,
  input  logic         uv_flag,
  input  logic         ov_flag,
  input  logic         ot_flag,
  input  logic         oc2_flag,
  input  logic         oc1_evt,
  input  logic         cyc_end,
  input  logic         softstop_en,
  output logic         run,
  output logic [W-1:0] clamp,
  output logic         latched
);
  localparam int CW = $clog2(TRIES + 1);
  localparam logic [W:0] K_BASE = (W+1)'(BASE);
  localparam logic [W:0] K_PLAT = (W+1)'(PLATEAU);
  localparam logic [W:0] K_OVLD = (W+1)'(OVLD);
  localparam logic [W:0] K_FAST = (W+1)'(FAST);
  localparam logic [W:0] K_SLOW = (W+1)'(SLOW);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_RAMP, S_RUN, S_SLOWHIC, S_FASTHIC, S_SOFT, S_QUIT, S_LOCK
  } st_t;

  st_t           st, brk_to;
  logic [W-1:0]  lvl;
  logic [CW-1:0] tries;
  logic [W:0]    up_f, up_s, dn_f, dn_s;
  logic          hard, brk, start;

  assign up_f  = {1'b0, lvl} + K_FAST;
  assign up_s  = {1'b0, lvl} + K_SLOW;
  assign dn_f  = ({1'b0, lvl} > K_FAST) ? {1'b0, lvl} - K_FAST : '0;
  assign dn_s  = ({1'b0, lvl} > K_SLOW) ? {1'b0, lvl} - K_SLOW : '0;
  assign hard  = ov_flag | oc2_flag;
  assign start = pgood & ~uv_flag & ~ot_flag;

  always_comb begin
    brk    = 1'b1;
    brk_to = S_FASTHIC;
    if (hard)                          brk_to = S_FASTHIC;
    else if (uv_flag)                  brk_to = S_QUIT;
    else if (ot_flag)                  brk_to = S_SOFT;
    else if (!pgood && softstop_en)    brk_to = S_SOFT;
    else if (!pgood)                   brk_to = S_QUIT;
    else                               brk    = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      lvl   <= '0;
      tries <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          lvl <= '0;
          if (start) st <= S_PRE;
        end
        S_PRE, S_RAMP, S_RUN: begin
          if (brk) begin
            st <= brk_to;
            if (brk_to == S_FASTHIC && tries < CW'(TRIES)) tries <= tries + 1'b1;
          end else if (st == S_PRE) begin
            if (up_f >= K_BASE) begin
              lvl <= W'(K_BASE);
              st  <= S_RAMP;
            end else lvl <= up_f[W-1:0];
          end else if (st == S_RAMP) begin
            if (up_s >= K_PLAT) begin
              lvl   <= W'(K_PLAT);
              st    <= S_RUN;
              tries <= '0;
            end else lvl <= up_s[W-1:0];
          end else if (cyc_end) begin
            if (oc1_evt) begin
              if (up_s >= K_OVLD) begin
                lvl <= W'(K_OVLD);
                st  <= S_SLOWHIC;
              end else lvl <= up_s[W-1:0];
            end else if ({1'b0, lvl} > K_PLAT) begin
              lvl <= (dn_s < K_PLAT) ? W'(K_PLAT) : dn_s[W-1:0];
            end
          end
        end
        S_SLOWHIC, S_SOFT: begin
          if (hard) begin
            st <= S_FASTHIC;
            if (tries < CW'(TRIES)) tries <= tries + 1'b1;
          end else if (uv_flag) st <= S_QUIT;
          else begin
            lvl <= (st == S_SOFT) ? dn_f[W-1:0] : dn_s[W-1:0];
            if (((st == S_SOFT) ? dn_f : dn_s) == '0) st <= S_IDLE;
          end
        end
        S_FASTHIC: begin
          lvl <= dn_f[W-1:0];
          if (dn_f == '0) st <= (tries >= CW'(TRIES)) ? S_LOCK : S_IDLE;
        end
        S_QUIT: begin
          lvl <= dn_f[W-1:0];
          if (dn_f == '0) st <= S_IDLE;
        end
        default: begin
          st  <= S_LOCK;
          lvl <= '0;
        end
      endcase
    end
  end

  assign run     = (st == S_RAMP) || (st == S_RUN) || (st == S_SOFT);
  assign clamp   = lvl;
  assign latched = (st == S_LOCK);

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> latched);
  assert_latch_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latched |-> (!run && clamp == '0));
  assert_hard_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hard |=> !run);
  assert_uv_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> !run);
  assert_ceiling_R11: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, clamp} <= K_OVLD);
  assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((clamp >= $past(clamp)) ? ({1'b0, clamp} - {1'b0, $past(clamp)})
                                      : ({1'b0, $past(clamp)} - {1'b0, clamp})) <= K_FAST);
endmodule

// File: tb/test_ss_hiccup_seq.sv
module test_ss_hiccup_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pgood = 0, uv_flag = 0, ov_flag = 0, ot_flag = 0, oc2_flag = 0, oc1_evt = 0;
  logic cyc_end = 1, softstop_en = 1;
  logic run, latched;
  logic [7:0] clamp;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  ss_hiccup_seq i_ss_hiccup_seq (
    .clk(clk), .rst_n(rst_n), .pgood(pgood), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .ot_flag(ot_flag), .oc2_flag(oc2_flag), .oc1_evt(oc1_evt), .cyc_end(cyc_end),
    .softstop_en(softstop_en), .run(run), .clamp(clamp), .latched(latched)
  );

  // {pgood,uv,ov,ot,oc2,oc1,mode, clocks[7:0], clamp[7:0], run, latched}
  localparam logic [24:0] VEC [14] = '{
    {7'b1000001, 8'd3,  8'd10, 1'b0, 1'b0},  // R2 pre-charge
    {7'b1000001, 8'd2,  8'd20, 1'b1, 1'b0},  // R2 baseline
    {7'b1000001, 8'd40, 8'd60, 1'b1, 1'b0},  // R2 plateau
    {7'b1000001, 8'd5,  8'd60, 1'b1, 1'b0},  // R3 hold
    {7'b1000011, 8'd10, 8'd70, 1'b1, 1'b0},  // R3 rise
    {7'b1000001, 8'd4,  8'd66, 1'b1, 1'b0},  // R3 fall back
    {7'b1000011, 8'd14, 8'd80, 1'b0, 1'b0},  // R4 ceiling
    {7'b1000001, 8'd80, 8'd0,  1'b0, 1'b0},  // R4 slow discharge
    {7'b1000001, 8'd5,  8'd20, 1'b1, 1'b0},  // R4 restart
    {7'b1000001, 8'd40, 8'd60, 1'b1, 1'b0},  // R2 plateau again
    {7'b1000101, 8'd1,  8'd60, 1'b0, 1'b0},  // R5 fast stop
    {7'b1000001, 8'd12, 8'd0,  1'b0, 1'b0},  // R5 fast discharge
    {7'b1010001, 8'd9,  8'd0,  1'b0, 1'b1},  // R6 lock
    {7'b1000001, 8'd20, 8'd0,  1'b0, 1'b1}   // R6 stays locked
  };
  localparam string TAG [14] = '{"R2","R2","R2","R3","R3","R3","R4/R11","R4","R4",
                                 "R2","R5","R5","R6","R6"};

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk3(input string tag, input int c, input int r, input int l);
    chk({tag, " clamp"}, int'(clamp), c);
    chk({tag, " run"}, int'(run), r);
    chk({tag, " latched"}, int'(latched), l);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    {pgood, uv_flag, ov_flag, ot_flag, oc2_flag, oc1_evt} = '0;
    softstop_en = 1;
    step(3);
    rst_n = 1;
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk3("R1 reset", 0, 0, 0);
    step(4);
    chk3("R1 no start without pgood", 0, 0, 0);

    for (int i = 0; i < 14; i++) begin
      {pgood, uv_flag, ov_flag, ot_flag, oc2_flag, oc1_evt, softstop_en} = VEC[i][24:18];
      step(int'(VEC[i][17:10]));
      chk3(TAG[i], int'(VEC[i][9:2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end

    // R7 over-temperature soft stop
    do_reset(); pgood = 1; step(45);
    chk3("R7 running", 60, 1, 0);
    ot_flag = 1; step(1);
    chk3("R7 soft stop entry", 60, 1, 0);
    step(5);
    chk3("R7 gates still switching", 35, 1, 0);
    step(12);
    chk3("R7 waits for ot", 0, 0, 0);
    ot_flag = 0; step(5);
    chk3("R7 restart", 20, 1, 0);

    // R9 pgood loss with soft stop enabled
    step(40);
    pgood = 0; step(2);
    chk3("R9 soft stop", 55, 1, 0);
    step(11);
    chk3("R9 soft stop done", 0, 0, 0);

    // R9 pgood loss with soft stop disabled
    pgood = 1; step(45);
    softstop_en = 0; pgood = 0; step(1);
    chk3("R9 immediate stop", 60, 0, 0);
    step(12);
    chk3("R9 discharged", 0, 0, 0);

    // R8 undervoltage
    softstop_en = 1; pgood = 1; step(45);
    uv_flag = 1; step(1);
    chk3("R8 fast off", 60, 0, 0);
    step(17);
    chk3("R8 waits for uv", 0, 0, 0);
    uv_flag = 0; step(5);
    chk3("R8 restart", 20, 1, 0);

    // R10 attempt count cleared at plateau
    do_reset(); pgood = 1; step(45);
    for (int k = 0; k < 2; k++) begin
      oc2_flag = 1; step(1);
      oc2_flag = 0; step(12);
      oc2_flag = 1; step(6);
      oc2_flag = 0; step(45);
      chk3("R10 restart after three hiccups", 60, 1, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule